// File: doc/BRIEF.md
# Microprogram Sequencer

This block is the control unit of a single-bus, multi-cycle processor datapath. It keeps a micro-program counter and reads a built-in control store. It emits one control word per clock that tells the datapath which source drives the shared bus and which registers load from it. The bus sources are the register file, the ALU, the immediate extender and memory; the loading registers are A, B, the memory address register, the instruction register, the PC and the register-file write port.

Each micro-instruction holds the control word, a three-bit jump kind and an absolute target. The micro-PC is never stored in full in the word. The jump kind picks the next micro-PC from six sources: the micro-PC plus one, a hold while memory reports busy, the absolute target, the start of the current opcode's routine, or one of two branches that test the datapath's zero flag. The control store implements instruction fetch and then a routine for each opcode group: register ALU, immediate ALU, load, store, jump, jump-register, jump-and-link, jump-and-link-register, the two conditional branches and a memory-to-memory ALU operation.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `upc_o` is 0 at once, with no clock edge needed. At address 0, `ctrl_o` is the first fetch step: reg_sel=3 (PC), en_reg=1, ld_ma=1 and every other bit 0, which gives 0x0C028.
- R2: After a step of kind "next", `upc_o` advances by one at the next rising edge. Fetch runs through addresses 0, 1, 2, 3 in order.
- R3: On a "spin" step, `upc_o` stays put at each edge while `busy_i` is 1. It advances by one at the first edge where `busy_i` is 0. Address 1 (instruction read) is a spin step.
- R4: Every routine ends by returning `upc_o` to 0. With `busy_i` low, a routine lasts the following number of cycles from its first address until `upc_o` is 0 again: register ALU 3, immediate ALU 3, load 5, store 5, jump 3, jump-register 1, jump-and-link 4, jump-and-link-register 3, memory-to-memory ALU 7.
- R5: Address 3 dispatches on `opcode_i` to a routine start. The opcodes and their starts are: 0→4 (register ALU), 1→7 (immediate ALU), 2→10 (load), 3→15 (store), 4→20 (jump), 5→23 (jump-register), 6→24 (jump-and-link), 7→28 (jump-and-link-register), 8→31 (branch-if-zero), 9→36 (branch-if-not-zero), 10→41 (memory-to-memory ALU).
- R6: The branch-if-zero routine (start 31) lasts 5 cycles when `zero_i`=1 and 2 cycles when `zero_i`=0. The branch-if-not-zero routine (start 36) lasts 5 cycles when `zero_i`=0 and 2 cycles when `zero_i`=1.
- R7: An unassigned opcode (11 to 63) dispatches to halt address 48. There `ctrl_o` is 0 and `upc_o` stays 48 whatever `opcode_i`, `zero_i` and `busy_i` do, until reset.
- R8: In every step, at most one bus source is enabled. The bus sources are en_reg (bit 5), en_alu (bit 8), en_imm (bit 9), and en_mem (bit 7) when mem_wr (bit 6) is 0.
- R9: The load routine forms the address at address 12, with `ctrl_o`=0x00508 (en_alu, alu_op=1 (add), ld_ma). It then writes memory data to rf2 at address 13, with `ctrl_o`=0x04090 (reg_sel=1, en_mem, reg_wr). Address 13 is a spin step.
- R10: Jump-and-link writes the link register at address 25, with `ctrl_o`=0x10110 (reg_sel=4, en_alu, alu_op=0 pass-A, reg_wr). It loads the PC with A+B at address 27, with `ctrl_o`=0x20500 (ld_pc, alu_op=1, en_alu).
- R11: `busy_i` has no effect on steps that are not spin steps.

Control word layout, from bit 0 upward: ld_ir[0], ld_a[1], ld_b[2], ld_ma[3], reg_wr[4], en_reg[5], mem_wr[6], en_mem[7], en_alu[8], en_imm[9], alu_op[11:10], ext_sel[13:12], reg_sel[16:14], ld_pc[17].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | OPC_W (6) | Opcode from the instruction register |
| zero_i | input | 1 | Datapath zero flag for register A |
| busy_i | input | 1 | Memory busy |
| ctrl_o | output | 18 | Datapath control word of the current step |
| upc_o | output | UPC_W (6) | Current micro-PC |

## Verification
The assertions assume that `opcode_i` and `zero_i` are settled before each rising edge and are steady while a dispatch or a zero-tested step is under way. They also assume that `busy_i` is a level that the sequencer samples only on spin steps. The bench changes all inputs on the falling edge only. It holds the opcode and the zero flag for a whole instruction. It raises busy both on spin steps and on plain steps, so that the hold and the no-effect cases are both covered.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UA_W = 6;

  typedef enum logic [2:0] {JT_NEXT, JT_SPIN, JT_FETCH, JT_DISP, JT_FEQZ, JT_FNEZ} jump_e;
  typedef enum logic [2:0] {SRC_RF1, SRC_RF2, SRC_RF3, SRC_PC, SRC_LINK} rsel_e;
  typedef enum logic [1:0] {ALU_PASS_A, ALU_ADD, ALU_INC4, ALU_FUNC} alu_e;
  typedef enum logic [1:0] {EXT_S16, EXT_U16, EXT_S26} ext_e;

  typedef struct packed {
    logic  ld_pc;
    rsel_e reg_sel;
    ext_e  ext_sel;
    alu_e  alu_op;
    logic  en_imm;
    logic  en_alu;
    logic  en_mem;
    logic  mem_wr;
    logic  en_reg;
    logic  reg_wr;
    logic  ld_ma;
    logic  ld_b;
    logic  ld_a;
    logic  ld_ir;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    ctrl_t           ctrl;
    jump_e           jt;
    logic [UA_W-1:0] abs;
  } uword_t;

  // routine start addresses
  localparam int A_FETCH = 0;
  localparam int A_ALU   = 4;
  localparam int A_ALUI  = 7;
  localparam int A_LW    = 10;
  localparam int A_SW    = 15;
  localparam int A_J     = 20;
  localparam int A_JR    = 23;
  localparam int A_JAL   = 24;
  localparam int A_JALR  = 28;
  localparam int A_BEQZ  = 31;
  localparam int A_BNEZ  = 36;
  localparam int A_ALUMM = 41;
  localparam int A_HALT  = 48;

  function automatic uword_t ucode(input int a);
    uword_t w;
    w     = '0;
    w.jt  = JT_NEXT;
    w.abs = UA_W'(A_FETCH);
    case (a)
      0: begin w.ctrl.reg_sel = SRC_PC; w.ctrl.en_reg = 1'b1; w.ctrl.ld_ma = 1'b1; end
      1: begin w.ctrl.en_mem = 1'b1; w.ctrl.ld_ir = 1'b1; w.jt = JT_SPIN; end
      2, 20, 24, 28, 33, 38: begin
        w.ctrl.reg_sel = SRC_PC; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1;
      end
      3: begin
        w.ctrl.en_alu = 1'b1; w.ctrl.alu_op = ALU_INC4; w.ctrl.ld_pc = 1'b1; w.jt = JT_DISP;
      end
      4, 7, 10, 15, 31, 36: begin
        w.ctrl.reg_sel = SRC_RF1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1;
      end
      5: begin w.ctrl.reg_sel = SRC_RF2; w.ctrl.en_reg = 1'b1; w.ctrl.ld_b = 1'b1; end
      6, 9: begin
        w.ctrl.en_alu = 1'b1; w.ctrl.alu_op = ALU_FUNC; w.ctrl.reg_sel = SRC_RF3;
        w.ctrl.reg_wr = 1'b1; w.jt = JT_FETCH;
      end
      8, 11, 16, 34, 39: begin
        w.ctrl.en_imm = 1'b1; w.ctrl.ext_sel = EXT_S16; w.ctrl.ld_b = 1'b1;
      end
      12, 17: begin w.ctrl.en_alu = 1'b1; w.ctrl.alu_op = ALU_ADD; w.ctrl.ld_ma = 1'b1; end
      13: begin
        w.ctrl.en_mem = 1'b1; w.ctrl.reg_sel = SRC_RF2; w.ctrl.reg_wr = 1'b1; w.jt = JT_SPIN;
      end
      14, 19, 47: w.jt = JT_FETCH;
      18: begin
        w.ctrl.reg_sel = SRC_RF2; w.ctrl.en_reg = 1'b1; w.ctrl.en_mem = 1'b1;
        w.ctrl.mem_wr = 1'b1; w.jt = JT_SPIN;
      end
      21, 26: begin w.ctrl.en_imm = 1'b1; w.ctrl.ext_sel = EXT_S26; w.ctrl.ld_b = 1'b1; end
      22, 27, 35, 40: begin
        w.ctrl.en_alu = 1'b1; w.ctrl.alu_op = ALU_ADD; w.ctrl.ld_pc = 1'b1; w.jt = JT_FETCH;
      end
      23, 30: begin
        w.ctrl.reg_sel = SRC_RF1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_pc = 1'b1; w.jt = JT_FETCH;
      end
      25, 29: begin
        w.ctrl.en_alu = 1'b1; w.ctrl.alu_op = ALU_PASS_A; w.ctrl.reg_sel = SRC_LINK;
        w.ctrl.reg_wr = 1'b1;
      end
      32: w.jt = JT_FNEZ;
      37: w.jt = JT_FEQZ;
      41: begin w.ctrl.reg_sel = SRC_RF1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_ma = 1'b1; end
      42: begin w.ctrl.en_mem = 1'b1; w.ctrl.ld_a = 1'b1; w.jt = JT_SPIN; end
      43: begin w.ctrl.reg_sel = SRC_RF2; w.ctrl.en_reg = 1'b1; w.ctrl.ld_ma = 1'b1; end
      44: begin w.ctrl.en_mem = 1'b1; w.ctrl.ld_b = 1'b1; w.jt = JT_SPIN; end
      45: begin w.ctrl.reg_sel = SRC_RF3; w.ctrl.en_reg = 1'b1; w.ctrl.ld_ma = 1'b1; end
      46: begin
        w.ctrl.en_alu = 1'b1; w.ctrl.alu_op = ALU_FUNC; w.ctrl.en_mem = 1'b1;
        w.ctrl.mem_wr = 1'b1; w.jt = JT_SPIN;
      end
      default: begin w.jt = JT_FETCH; w.abs = UA_W'(A_HALT); end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int UPC_W = useq_pkg::UA_W
) (
  input  logic [UPC_W-1:0] addr_i,
  output useq_pkg::uword_t word_o
);
  localparam int DEPTH = 1 << UPC_W;

  useq_pkg::uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = useq_pkg::ucode(i);
  end

  assign word_o = rom[addr_i];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int OPC_W = 6,
  parameter int UPC_W = useq_pkg::UA_W
) (
  input  logic [OPC_W-1:0] opcode_i,
  output logic [UPC_W-1:0] start_o
);
  import useq_pkg::*;

  always_comb begin
    case (int'(opcode_i))
      0:       start_o = UPC_W'(A_ALU);
      1:       start_o = UPC_W'(A_ALUI);
      2:       start_o = UPC_W'(A_LW);
      3:       start_o = UPC_W'(A_SW);
      4:       start_o = UPC_W'(A_J);
      5:       start_o = UPC_W'(A_JR);
      6:       start_o = UPC_W'(A_JAL);
      7:       start_o = UPC_W'(A_JALR);
      8:       start_o = UPC_W'(A_BEQZ);
      9:       start_o = UPC_W'(A_BNEZ);
      10:      start_o = UPC_W'(A_ALUMM);
      default: start_o = UPC_W'(A_HALT);
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int UPC_W = useq_pkg::UA_W
) (
  input  useq_pkg::jump_e  jt_i,
  input  logic [UPC_W-1:0] upc_i,
  input  logic [UPC_W-1:0] abs_i,
  input  logic [UPC_W-1:0] start_i,
  input  logic             zero_i,
  input  logic             busy_i,
  output logic [UPC_W-1:0] upc_n_o
);
  import useq_pkg::*;

  logic [UPC_W-1:0] inc;
  assign inc = upc_i + 1'b1;

  always_comb begin
    case (jt_i)
      JT_NEXT:  upc_n_o = inc;
      JT_SPIN:  upc_n_o = busy_i ? upc_i : inc;
      JT_FETCH: upc_n_o = abs_i;
      JT_DISP:  upc_n_o = start_i;
      JT_FEQZ:  upc_n_o = zero_i ? abs_i : inc;
      JT_FNEZ:  upc_n_o = zero_i ? inc : abs_i;
      default:  upc_n_o = upc_i;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int OPC_W = 6,
  parameter int UPC_W = useq_pkg::UA_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [OPC_W-1:0]            opcode_i,
  input  logic                        zero_i,
  input  logic                        busy_i,
  output logic [useq_pkg::CTRL_W-1:0] ctrl_o,
  output logic [UPC_W-1:0]            upc_o
);
  import useq_pkg::*;

  logic [UPC_W-1:0] upc_q, upc_n, start, abs_addr;
  uword_t           word;
  jump_e            jt;

  useq_rom #(.UPC_W(UPC_W)) u_rom (
    .addr_i (upc_q),
    .word_o (word)
  );

  useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W)) u_disp (
    .opcode_i (opcode_i),
    .start_o  (start)
  );

  assign jt       = word.jt;
  assign abs_addr = UPC_W'(word.abs);

  useq_next #(.UPC_W(UPC_W)) u_next (
    .jt_i    (jt),
    .upc_i   (upc_q),
    .abs_i   (abs_addr),
    .start_i (start),
    .zero_i  (zero_i),
    .busy_i  (busy_i),
    .upc_n_o (upc_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_n;
  end

  assign ctrl_o = word.ctrl;
  assign upc_o  = upc_q;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int UPC_W = useq_pkg::UA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [UPC_W-1:0] upc_i,
  input useq_pkg::jump_e  jt_i,
  input logic [UPC_W-1:0] abs_i,
  input logic [UPC_W-1:0] start_i,
  input logic             zero_i,
  input logic             busy_i,
  input useq_pkg::ctrl_t  ctrl_i
);
  import useq_pkg::*;

  p_next_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jt_i == JT_NEXT |=> upc_i == UPC_W'($past(upc_i) + 1'b1));

  p_spin_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jt_i == JT_SPIN && busy_i) |=> $stable(upc_i));

  p_spin_go_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jt_i == JT_SPIN && !busy_i) |=> upc_i == UPC_W'($past(upc_i) + 1'b1));

  p_fetch_abs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jt_i == JT_FETCH |=> upc_i == $past(abs_i));

  p_dispatch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jt_i == JT_DISP |=> upc_i == $past(start_i));

  p_feqz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jt_i == JT_FEQZ && zero_i) |=> upc_i == $past(abs_i));

  p_fnez_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jt_i == JT_FNEZ && !zero_i) |=> upc_i == $past(abs_i));

  p_halt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_i == UPC_W'(A_HALT) |=> upc_i == UPC_W'(A_HALT));

  p_one_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ctrl_i.en_reg, ctrl_i.en_alu, ctrl_i.en_imm,
                ctrl_i.en_mem & ~ctrl_i.mem_wr}) <= 1);
endmodule

bind useq_ctrl useq_ctrl_chk #(.UPC_W(UPC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .upc_i   (upc_q),
  .jt_i    (jt),
  .abs_i   (abs_addr),
  .start_i (start),
  .zero_i  (zero_i),
  .busy_i  (busy_i),
  .ctrl_i  (word.ctrl)
);

// File: tb/tb_useq_ctrl.sv
module tb_useq_ctrl;
  localparam int CW = 18;
  localparam logic [CW-1:0] C_FETCH0 = CW'((3 << 14) | (1 << 5) | (1 << 3));
  localparam logic [CW-1:0] C_LW_ADDR = CW'((1 << 10) | (1 << 8) | (1 << 3));
  localparam logic [CW-1:0] C_LW_DATA = CW'((1 << 14) | (1 << 7) | (1 << 4));
  localparam logic [CW-1:0] C_JAL_LNK = CW'((4 << 14) | (1 << 8) | (1 << 4));
  localparam logic [CW-1:0] C_JAL_PC  = CW'((1 << 17) | (1 << 10) | (1 << 8));

  // opcode, zero, start, length
  localparam int NV = 13;
  localparam int VEC [NV][4] = '{
    '{0, 0, 4, 3}, '{1, 0, 7, 3}, '{2, 0, 10, 5}, '{3, 0, 15, 5},
    '{4, 0, 20, 3}, '{5, 0, 23, 1}, '{6, 0, 24, 4}, '{7, 0, 28, 3},
    '{8, 1, 31, 5}, '{8, 0, 31, 2}, '{9, 0, 36, 5}, '{9, 1, 36, 2},
    '{10, 0, 41, 7}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [5:0]    opcode_i;
  logic          zero_i, busy_i;
  logic [CW-1:0] ctrl_o;
  logic [5:0]    upc_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  useq_ctrl dut (
    .clk_i, .rst_ni, .opcode_i, .zero_i, .busy_i, .ctrl_o, .upc_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int n_sources(input logic [CW-1:0] c);
    return int'(c[5]) + int'(c[8]) + int'(c[9]) + int'(c[7] & ~c[6]);
  endfunction

  task automatic to_dispatch(input int op, input int z);
    opcode_i = 6'(op);
    zero_i   = z[0];
    busy_i   = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic run_vec(input int op, input int z, input int st, input int len);
    int steps = 0;
    int bad   = 0;
    chk(upc_o == 6'd0, "R4", "upc before instruction", int'(upc_o), 0);
    to_dispatch(op, z);
    chk(upc_o == 6'(st), "R5", $sformatf("start for opcode %0d", op), int'(upc_o), st);
    while (upc_o != 6'd0 && steps < 20) begin
      if (n_sources(ctrl_o) > 1) bad++;
      steps++;
      @(negedge clk_i);
    end
    chk(steps == len, (op == 8 || op == 9) ? "R6" : "R4",
        $sformatf("length op %0d zero %0d", op, z), steps, len);
    chk(bad == 0, "R8", "steps with several bus sources", bad, 0);
  endtask

  initial begin
    rst_ni = 1'b0; opcode_i = '0; zero_i = 1'b0; busy_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(upc_o == 6'd0, "R1", "upc in reset", int'(upc_o), 0);
    chk(ctrl_o == C_FETCH0, "R1", "fetch0 word", int'(ctrl_o), int'(C_FETCH0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(upc_o == 6'd1, "R2", "fetch step advance", int'(upc_o), 1);
    repeat (5) @(negedge clk_i);  // 1->2->3->dispatch 0->4->5->6
    @(negedge clk_i);
    chk(upc_o == 6'd0, "R4", "first ALU back to fetch", int'(upc_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // R3 spin on instruction read, R11 busy on plain step
    busy_i = 1'b1; opcode_i = 6'd0;
    @(negedge clk_i);
    chk(upc_o == 6'd1, "R11", "busy ignored at step 0", int'(upc_o), 1);
    repeat (3) @(negedge clk_i);
    chk(upc_o == 6'd1, "R3", "spin holds while busy", int'(upc_o), 1);
    busy_i = 1'b0;
    @(negedge clk_i);
    chk(upc_o == 6'd2, "R3", "spin releases", int'(upc_o), 2);
    busy_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(upc_o == 6'd4, "R11", "dispatch with busy", int'(upc_o), 4);
    @(negedge clk_i);
    chk(upc_o == 6'd5, "R11", "next step with busy", int'(upc_o), 5);
    busy_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // R9 load words
    to_dispatch(2, 0);
    repeat (2) @(negedge clk_i);
    chk(upc_o == 6'd12 && ctrl_o == C_LW_ADDR, "R9", "load address word",
        int'(ctrl_o), int'(C_LW_ADDR));
    busy_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(upc_o == 6'd13, "R3", "load data spin hold", int'(upc_o), 13);
    chk(ctrl_o == C_LW_DATA, "R9", "load data word", int'(ctrl_o), int'(C_LW_DATA));
    busy_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(upc_o == 6'd0, "R4", "load end", int'(upc_o), 0);

    // R10 jump-and-link words
    to_dispatch(6, 0);
    @(negedge clk_i);
    chk(ctrl_o == C_JAL_LNK, "R10", "link write word", int'(ctrl_o), int'(C_JAL_LNK));
    repeat (2) @(negedge clk_i);
    chk(ctrl_o == C_JAL_PC, "R10", "pc load word", int'(ctrl_o), int'(C_JAL_PC));
    @(negedge clk_i);

    // R7 halt
    to_dispatch(63, 0);
    chk(upc_o == 6'd48, "R7", "unused opcode to halt", int'(upc_o), 48);
    chk(ctrl_o == '0, "R7", "halt word", int'(ctrl_o), 0);
    for (int k = 0; k < 4; k++) begin
      opcode_i = 6'(k); zero_i = k[0]; busy_i = k[1];
      @(negedge clk_i);
    end
    chk(upc_o == 6'd48, "R7", "halt holds", int'(upc_o), 48);
    #5 rst_ni = 1'b0;
    #2 chk(upc_o == 6'd0, "R1", "async reset from halt", int'(upc_o), 0);
    @(negedge clk_i);
    chk(ctrl_o == C_FETCH0, "R1", "word after reset", int'(ctrl_o), int'(C_FETCH0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule